// File: doc/BRIEF.md
# Per-Channel Interrupt Coalescing Unit

This block decides when each channel of a multi-channel DMA engine interrupts the processor. Each channel counts its completed packets. It raises its interrupt request once the count reaches a programmable threshold, or once a millisecond timer expires while at least one packet is waiting, whichever comes first. Fewer interrupts then reach the processor at high packet rates, and a lone packet still gets serviced within a bounded time.

Software programs two 10-bit settings per channel through a simple write port. The port carries a 32-bit control word and a two-bit field select. A zero in either setting turns that path off for the channel. The DMA engine supplies one packet-done strobe per channel. A shared strobe marks each elapsed millisecond. Software clears a pending request with a per-channel acknowledge.

Top module: `irq_coalesce`

## Requirements
- R1: An active-low asynchronous reset clears every packet counter, every timer, every stored setting and every pending request; `irq_o` is all zero while reset is asserted.
- R2: With a nonzero threshold, the packet strobe that brings a channel's count up to the threshold makes that channel's `irq_o` rise at the next clock edge.
- R3: A threshold of 0 disables the count path: no number of packets raises the request on its own.
- R4: With a nonzero wait bound W, the first packet after the last interrupt starts a timer. The request rises at the clock edge that samples the W-th `ms_tick_i` pulse after that packet, even when the count is below the threshold. A tick in the same cycle as the starting packet is not counted.
- R5: A wait bound of 0 disables the timer path.
- R6: In the control word, bits 9:0 hold the threshold and bits 25:16 hold the wait bound. `cfg_be_i[0]` enables the threshold write and `cfg_be_i[1]` enables the wait-bound write. A field whose enable is low keeps its value.
- R7: A raised request stays high until `irq_ack_i` for that channel is high at a clock edge; it then reads low after that edge.
- R8: Raising a request by either path clears the channel's packet count and stops its timer, so the next request needs a full threshold or a fresh wait bound.
- R9: Packets that arrive while a request is pending are still counted. If the count already meets the threshold when the request is acknowledged, the request is low for one cycle and rises again at the following edge.
- R10: Channels are independent: packets, settings and acknowledges of one channel never change another channel's request, and several channels may rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_ch_i | input | CH_W | Channel addressed by the write |
| cfg_be_i | input | 2 | Field enables: bit 0 threshold, bit 1 wait bound |
| cfg_wdata_i | input | WORD_W | Control word: threshold in 9:0, wait bound in 25:16 |
| pkt_done_i | input | N_CH | One-cycle packet completion strobe per channel |
| ms_tick_i | input | 1 | One-cycle pulse per elapsed millisecond |
| irq_ack_i | input | N_CH | Per-channel acknowledge of a pending request |
| irq_o | output | N_CH | Per-channel interrupt request |

## Verification
The count path is tried with a run of packets below the threshold and then the one that reaches it. This shows whether the comparison fires on the right packet and whether the counter restarts from zero afterwards. The timer path is tried with packets spaced by ticks so that the bound expires before the threshold, and again with the bound at zero, which separates a running timer from a disabled one. Field-selective writes are each followed by traffic that exercises the field left untouched, so a clobbered neighbour field shows up as a missing or early request. Simultaneous strobes on two channels, and packets landing while a request is pending, tell apart per-channel state from shared state and show whether the re-raise after acknowledge happens.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned FIELD_W = 10;
  localparam int unsigned THR_LSB = 0;
  localparam int unsigned WB_LSB  = 16;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_THR  = 2'b01,
    SEL_WB   = 2'b10,
    SEL_BOTH = 2'b11
  } field_sel_e;
endpackage

// File: rtl/icu_sat_cnt.sv
module icu_sat_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] sum_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // sum_o is the value after this cycle's increment, before any clear
  assign sum_o = (inc_i && cnt_q != MAX) ? cnt_q + W'(1) : cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= sum_o;
  end
endmodule

// File: rtl/icu_cfg_bank.sv
module icu_cfg_bank #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = icu_pkg::FIELD_W,
  parameter int unsigned THR_LSB = icu_pkg::THR_LSB,
  parameter int unsigned WB_LSB  = icu_pkg::WB_LSB,
  parameter int unsigned WORD_W  = icu_pkg::WORD_W,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CH_W-1:0]                 ch_i,
  input  logic [1:0]                      be_i,
  input  logic [WORD_W-1:0]               wdata_i,
  output logic [N_CH-1:0][FIELD_W-1:0]    thr_o,
  output logic [N_CH-1:0][FIELD_W-1:0]    wb_o
);
  logic [FIELD_W-1:0] thr_new, wb_new;
  logic               unused_bits;

  assign thr_new = wdata_i[THR_LSB +: FIELD_W];
  assign wb_new  = wdata_i[WB_LSB  +: FIELD_W];
  assign unused_bits = ^{wdata_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = we_i && (ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        thr_o[c] <= '0;
        wb_o[c]  <= '0;
      end else if (hit) begin
        if (be_i[0]) thr_o[c] <= thr_new;
        if (be_i[1]) wb_o[c]  <= wb_new;
      end
    end
  end
endmodule

// File: rtl/icu_chan.sv
module icu_chan #(
  parameter int unsigned FIELD_W = icu_pkg::FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_i,
  input  logic               tick_i,
  input  logic               ack_i,
  input  logic [FIELD_W-1:0] thr_i,
  input  logic [FIELD_W-1:0] wb_i,
  output logic               irq_o
);
  logic               pend_q, tmr_on_q;
  logic [FIELD_W-1:0] pkt_cnt, pkt_sum, tmr_cnt, tmr_sum;
  logic               hit_cnt, hit_tmr, fire;
  logic               unused_cnt;

  icu_sat_cnt #(.W(FIELD_W)) u_pkt (
    .clk_i, .rst_ni,
    .inc_i (pkt_i),
    .clr_i (fire),
    .cnt_o (pkt_cnt),
    .sum_o (pkt_sum)
  );

  // timer held at zero while idle; the start tick is not counted
  icu_sat_cnt #(.W(FIELD_W)) u_tmr (
    .clk_i, .rst_ni,
    .inc_i (tick_i && tmr_on_q),
    .clr_i (fire || !tmr_on_q),
    .cnt_o (tmr_cnt),
    .sum_o (tmr_sum)
  );

  assign unused_cnt = ^{pkt_cnt, tmr_cnt};

  assign hit_cnt = (thr_i != '0) && (pkt_sum >= thr_i);
  assign hit_tmr = (wb_i  != '0) && tmr_on_q && (tmr_sum >= wb_i);
  // evaluated only while idle; a hit during pending waits for the ack
  assign fire    = !pend_q && (hit_cnt || hit_tmr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      tmr_on_q <= 1'b0;
    end else begin
      if (fire)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;

      if (fire)       tmr_on_q <= 1'b0;
      else if (pkt_i) tmr_on_q <= 1'b1;
    end
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = icu_pkg::FIELD_W,
  parameter int unsigned THR_LSB = icu_pkg::THR_LSB,
  parameter int unsigned WB_LSB  = icu_pkg::WB_LSB,
  parameter int unsigned WORD_W  = icu_pkg::WORD_W,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_be_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic [N_CH-1:0]   pkt_done_i,
  input  logic              ms_tick_i,
  input  logic [N_CH-1:0]   irq_ack_i,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0][FIELD_W-1:0] thr_w, wb_w;

  icu_cfg_bank #(
    .N_CH(N_CH), .FIELD_W(FIELD_W), .THR_LSB(THR_LSB),
    .WB_LSB(WB_LSB), .WORD_W(WORD_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .ch_i    (cfg_ch_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .thr_o   (thr_w),
    .wb_o    (wb_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    icu_chan #(.FIELD_W(FIELD_W)) u_chan (
      .clk_i, .rst_ni,
      .pkt_i  (pkt_done_i[c]),
      .tick_i (ms_tick_i),
      .ack_i  (irq_ack_i[c]),
      .thr_i  (thr_w[c]),
      .wb_i   (wb_w[c]),
      .irq_o  (irq_o[c])
    );
  end
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = 10,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_we_i,
  input logic [CH_W-1:0]              cfg_ch_i,
  input logic [1:0]                   cfg_be_i,
  input logic [N_CH-1:0]              pkt_done_i,
  input logic [N_CH-1:0]              irq_ack_i,
  input logic [N_CH-1:0]              irq_o,
  input logic [N_CH-1:0][FIELD_W-1:0] thr_i,
  input logic [N_CH-1:0][FIELD_W-1:0] wb_i
);
  for (genvar c = 0; c < N_CH; c++) begin : g_c
    p_thr_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_i[c] == FIELD_W'(1) && !irq_o[c] && pkt_done_i[c]) |=> irq_o[c]);

    p_both_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_i[c] == '0 && wb_i[c] == '0 && !irq_o[c]) |=> !irq_o[c]);

    p_keep_thr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_ch_i == CH_W'(c) && !cfg_be_i[0]) |=> $stable(thr_i[c]));

    p_keep_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_ch_i == CH_W'(c) && !cfg_be_i[1]) |=> $stable(wb_i[c]));

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && !irq_ack_i[c]) |=> irq_o[c]);

    p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && irq_ack_i[c]) |=> !irq_o[c]);
  end
endmodule

bind irq_coalesce icu_chk #(.N_CH(N_CH), .FIELD_W(FIELD_W)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_be_i,
  .pkt_done_i, .irq_ack_i, .irq_o,
  .thr_i (thr_w),
  .wb_i  (wb_w)
);

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
  localparam int NC = 4;
  localparam int CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_ch = '0;
  logic [1:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NC-1:0] pkt = '0, ack = '0, irq;
  logic tick = 1'b0;

  always #10 clk = ~clk;

  irq_coalesce #(.N_CH(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .pkt_done_i(pkt),
    .ms_tick_i(tick), .irq_ack_i(ack), .irq_o(irq)
  );

  typedef struct { int ch; int at; string req; } ev_t;
  ev_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NC-1:0] prev = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: every rising request must match the head of the scoreboard
  always @(negedge clk) begin
    ev_t e;
    if (rst_n) begin
      for (int i = 0; i < NC; i++) begin
        if (irq[i] && !prev[i]) begin
          if (q.size() == 0) chk(0, "R10", "unexpected rise on channel", i, -1);
          else begin
            e = q.pop_front();
            chk(e.ch == i && e.at == cyc, e.req, "rise ch*100000+cycle",
                i * 100000 + cyc, e.ch * 100000 + e.at);
          end
        end
      end
    end
    prev <= irq;
  end

  task automatic drive(logic [NC-1:0] p, logic t, logic [NC-1:0] a);
    @(negedge clk);
    pkt = p; tick = t; ack = a;
  endtask

  task automatic idle(int n);
    repeat (n) drive('0, 1'b0, '0);
  endtask

  task automatic expect_irq(int ch, int dly, string req);
    q.push_back('{ch, cyc + dly, req});
  endtask

  task automatic cfg(int ch, logic [1:0] be, int thr, int wb);
    @(negedge clk);
    pkt = '0; tick = 1'b0; ack = '0;
    cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_be = be;
    cfg_wdata = (32'(wb) << 16) | 32'(thr);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic level(int ch, logic exp, string req, string what);
    chk(irq[ch] === exp, req, what, int'(irq[ch]), int'(exp));
  endtask

  task automatic pkt_on(int ch);
    drive(NC'(1) << ch, 1'b0, '0);
  endtask

  task automatic acknowledge(int ch);
    drive('0, 1'b0, NC'(1) << ch);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == '0, "R1", "irq during reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(2);
    chk(irq == '0, "R1", "irq after reset", int'(irq), 0);

    // R2/R7: threshold 3 on channel 0
    cfg(0, 2'b11, 3, 0);
    pkt_on(0); idle(1); pkt_on(0); idle(1);
    level(0, 0, "R2", "below threshold");
    pkt_on(0); expect_irq(0, 1, "R2");
    idle(5);
    level(0, 1, "R7", "held without ack");
    acknowledge(0);
    level(0, 0, "R7", "cleared by ack");

    // R8: counter restarted by the interrupt
    pkt_on(0); pkt_on(0); idle(2);
    level(0, 0, "R8", "two packets after clear");
    pkt_on(0); expect_irq(0, 1, "R8");
    idle(1);
    // R9: packets during pending, re-raise after ack
    pkt_on(0); pkt_on(0); pkt_on(0); idle(1);
    drive('0, 1'b0, NC'(1)); expect_irq(0, 2, "R9");
    idle(1);
    level(0, 0, "R9", "one low cycle after ack");
    idle(1);
    level(0, 1, "R9", "re-raised from counted packets");
    acknowledge(0);
    level(0, 0, "R9", "cleared after second ack");

    // R3: both paths off on channel 1
    repeat (5) begin pkt_on(1); idle(1); end
    idle(2);
    level(1, 0, "R3", "threshold zero ignores packets");

    // R4/R6: wait bound 4 written alone
    cfg(1, 2'b10, 7, 4);
    pkt_on(1); idle(1);
    drive('0, 1'b1, '0); drive('0, 1'b1, '0); drive('0, 1'b1, '0); idle(1);
    level(1, 0, "R4", "three ticks");
    drive('0, 1'b1, '0); expect_irq(1, 1, "R4");
    idle(2);
    level(1, 1, "R6", "threshold stayed zero, timer fired");
    acknowledge(1);

    // R6: threshold write keeps wait bound
    cfg(1, 2'b01, 2, 0);
    pkt_on(1);
    drive('0, 1'b1, '0); drive('0, 1'b1, '0); drive('0, 1'b1, '0);
    drive('0, 1'b1, '0); expect_irq(1, 1, "R6");
    idle(2);
    acknowledge(1);
    pkt_on(1); pkt_on(1); expect_irq(1, 1, "R6");
    idle(2);
    acknowledge(1);

    // R5: wait bound cleared, threshold kept
    cfg(1, 2'b10, 0, 0);
    pkt_on(1);
    repeat (6) drive('0, 1'b1, '0);
    idle(1);
    level(1, 0, "R5", "timer disabled");
    pkt_on(1); expect_irq(1, 1, "R6");
    idle(2);
    acknowledge(1);

    // R10: two channels in the same cycle
    cfg(2, 2'b11, 2, 0);
    cfg(3, 2'b11, 2, 0);
    drive(4'b1100, 1'b0, '0);
    drive(4'b1100, 1'b0, '0); expect_irq(2, 1, "R10"); expect_irq(3, 1, "R10");
    idle(2);
    chk(irq == 4'b1100, "R10", "irq vector", int'(irq), 12);
    acknowledge(2);
    chk(irq == 4'b1000, "R10", "ack of ch2 only", int'(irq), 8);
    acknowledge(3);

    // R4/R8: timer beats a large threshold, then counter restarted
    cfg(2, 2'b11, 5, 2);
    pkt_on(2); drive('0, 1'b1, '0); pkt_on(2);
    drive('0, 1'b1, '0); expect_irq(2, 1, "R4");
    idle(2);
    acknowledge(2);
    repeat (4) pkt_on(2);
    idle(1);
    level(2, 0, "R8", "four after timer irq");
    pkt_on(2); expect_irq(2, 1, "R8");
    idle(2);
    acknowledge(2);

    idle(3);
    chk(q.size() == 0, "R2", "expected rises left", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL all: watchdog at cycle %0d expected finish before %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule